// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream input. It locks onto 188-byte packets that open with the sync byte 0x47, extracts the 13-bit packet identifier, and compares it with a bank of eight programmable identifier slots. A packet whose identifier hits an enabled slot is forwarded. Any other packet is dropped whole. The forwarded bytes leave as 32-bit words, 47 words for each packet, with the first and last words of each packet flagged.

Slot zero holds more than an identifier. It also carries the three global controls: forward everything, drop everything, and the byte order inside an output word. Software programs the slots through a simple write port: a slot address, a 32-bit data word and a write strobe. The keep/drop choice and the byte order are fixed once per packet, when the packet's third byte arrives. They stay fixed for the rest of that packet.

Top module: `ts_pid_filter`

## Requirements
- R1: After synchronous reset every slot holds identifier 0x1FFF with its enable cleared, and all three global controls are cleared. No word is output until a packet is forwarded, so a packet with identifier 0x1FFF is dropped.
- R2: A packet begins only on a valid byte that has in_sop high and the value 0x47. A valid byte with in_sop high and any other value is discarded, and the filter goes on hunting for a start.
- R3: The identifier is formed from bits [4:0] of packet byte 1 (as bits 12:8) and all of packet byte 2 (as bits 7:0). The upper three bits of byte 1 play no part. A packet is forwarded when an enabled slot holds the same identifier.
- R4: A slot whose enable bit is clear never matches, even when its identifier field equals the packet's identifier.
- R5: When the pass-all control (slot 0, bit 16) is set, every packet is forwarded whatever its identifier.
- R6: When the block-all control (slot 0, bit 13) is set, every packet is dropped. This holds even when pass-all is also set.
- R7: The keep/drop choice and the byte order are taken when packet byte 2 arrives. Slot writes made after that point do not change the current packet.
- R8: A forwarded packet yields exactly 47 output words. out_sop is high on the first word only, and out_eop is high on the last word only. A dropped packet yields no words.
- R9: With the byte-order control (slot 0, bit 14) clear, the earliest byte of each group of four sits in out_data[31:24]. With the control set, it sits in out_data[7:0].
- R10: Once a packet has started, in_sop is ignored until all 188 bytes have been taken. After that the filter hunts again. Idle cycles (in_valid low) inside a packet are skipped.
- R11: The slot register layout is identifier in bits [12:0] and enable in bit 15, with slots addressed 0 to 7. Bits 13, 14 and 16 act as controls only when written to slot 0; on any other slot they are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_sop | input | 1 | Marks the byte expected to be a packet's first byte |
| in_data | input | 8 | Stream byte |
| cfg_we | input | 1 | Slot write strobe |
| cfg_addr | input | 3 | Slot number |
| cfg_wdata | input | 32 | Slot register value |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 32 | Four packed packet bytes |
| out_sop | output | 1 | First word of a forwarded packet |
| out_eop | output | 1 | Last word of a forwarded packet |

## Verification
On every cycle, the assertions check the framing of the output. out_sop and out_eop appear only on valid words. Every forwarded packet opens with out_sop and closes with out_eop on its 47th word. No output word appears without an input byte in the cycle before, and reset clears the output at once. Only the directed scenarios can show which packets are kept: identifier matching, the enable bit, the pass-all and block-all controls and their priority, byte order, and the decision held against mid-packet writes. They also cover sync hunting, in_sop ignored mid-packet, and control bits ignored on slots other than slot 0.

// File: rtl/tspf_pkg.sv
package tspf_pkg;

    localparam int          PID_W      = 13;
    localparam int          PID_HI_W   = PID_W - 8;
    localparam logic [7:0]  SYNC_BYTE  = 8'h47;
    localparam logic [12:0] PID_PARKED = 13'h1FFF;

    // Register bit positions
    localparam int BIT_EN     = 15;
    localparam int BIT_BLOCK  = 13;
    localparam int BIT_LSBF   = 14;
    localparam int BIT_PASS   = 16;

    typedef logic [PID_W-1:0] pid_t;

    typedef struct packed {
        logic en;
        pid_t pid;
    } slot_t;

    typedef struct packed {
        logic pass_all;
        logic block_all;
        logic lsb_first;
    } ctrl_t;

    typedef enum logic {
        TRK_HUNT = 1'b0,
        TRK_PKT  = 1'b1
    } trk_state_e;

    function automatic slot_t slot_from_word(input logic [31:0] w);
        slot_t s;
        s.en  = w[BIT_EN];
        s.pid = w[PID_W-1:0];
        return s;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.pass_all  = w[BIT_PASS];
        c.block_all = w[BIT_BLOCK];
        c.lsb_first = w[BIT_LSBF];
        return c;
    endfunction

    function automatic slot_t slot_parked();
        slot_t s;
        s.en  = 1'b0;
        s.pid = PID_PARKED;
        return s;
    endfunction

endpackage

// File: rtl/tspf_slot_bank.sv
module tspf_slot_bank
    import tspf_pkg::*;
#(
    parameter int NSLOTS = 8,
    parameter int AW     = $clog2(NSLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  pid_t          pid,
    output logic          keep,
    output logic          lsb_first
);

    slot_t             slots_q [NSLOTS];
    ctrl_t             ctrl_q;
    logic [NSLOTS-1:0] hit_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOTS; i++) begin
                slots_q[i] <= slot_parked();
            end
            ctrl_q <= '0;
        end else if (cfg_we && (32'(cfg_addr) < NSLOTS)) begin
            slots_q[cfg_addr] <= slot_from_word(cfg_wdata);
            if (cfg_addr == '0) begin
                ctrl_q <= ctrl_from_word(cfg_wdata);
            end
        end
    end

    for (genvar g = 0; g < NSLOTS; g++) begin : g_cmp
        assign hit_v[g] = slots_q[g].en && (slots_q[g].pid == pid);
    end

    // Block-all outranks pass-all
    always_comb begin
        keep      = !ctrl_q.block_all && (ctrl_q.pass_all || (|hit_v));
        lsb_first = ctrl_q.lsb_first;
    end

endmodule

// File: rtl/tspf_sync_track.sv
module tspf_sync_track
    import tspf_pkg::*;
#(
    parameter int PKT_BYTES = 188,
    parameter int IDX_W     = $clog2(PKT_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic             keep_in,
    input  logic             lsb_in,
    output logic             byte_acc,
    output logic [IDX_W-1:0] byte_idx,
    output pid_t             pid,
    output logic             keep_q,
    output logic             lsb_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_PIDH = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_PIDL = IDX_W'(2);

    trk_state_e            state_q;
    logic [IDX_W-1:0]      idx_q;
    logic [PID_HI_W-1:0]   pid_hi_q;
    logic                  start;

    always_comb begin
        start    = in_valid && in_sop && (in_data == SYNC_BYTE);
        byte_acc = (state_q == TRK_PKT) ? in_valid : start;
        byte_idx = (state_q == TRK_PKT) ? idx_q : '0;
        pid      = {pid_hi_q, in_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TRK_HUNT;
            idx_q    <= '0;
            pid_hi_q <= '0;
            keep_q   <= 1'b0;
            lsb_q    <= 1'b0;
        end else begin
            unique case (state_q)
                TRK_HUNT: begin
                    if (start) begin
                        state_q <= TRK_PKT;
                        idx_q   <= IDX_W'(1);
                    end
                end
                TRK_PKT: begin
                    if (in_valid) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= TRK_HUNT;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= TRK_HUNT;
            endcase
            if (byte_acc && byte_idx == IDX_PIDH) begin
                pid_hi_q <= in_data[PID_HI_W-1:0];
            end
            if (byte_acc && byte_idx == IDX_PIDL) begin
                keep_q <= keep_in;
                lsb_q  <= lsb_in;
            end
        end
    end

endmodule

// File: rtl/tspf_word_pack.sv
module tspf_word_pack #(
    parameter int PKT_BYTES  = 188,
    parameter int WORD_BYTES = 4,
    parameter int IDX_W      = $clog2(PKT_BYTES),
    parameter int LANE_W     = $clog2(WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    byte_acc,
    input  logic [IDX_W-1:0]        byte_idx,
    input  logic [7:0]              in_data,
    input  logic                    keep,
    input  logic                    lsb_first,
    output logic                    out_valid,
    output logic [8*WORD_BYTES-1:0] out_data,
    output logic                    out_sop,
    output logic                    out_eop
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);
    localparam logic [IDX_W-1:0]  FIRST_END = IDX_W'(WORD_BYTES - 1);
    localparam logic [IDX_W-1:0]  PKT_END   = IDX_W'(PKT_BYTES - 1);

    logic [7:0]              held_q [WORD_BYTES];
    logic [7:0]              full   [WORD_BYTES];
    logic [8*WORD_BYTES-1:0] word_msbf;
    logic [8*WORD_BYTES-1:0] word_lsbf;
    logic [LANE_W-1:0]       lane;
    logic                    word_done;

    assign lane      = byte_idx[LANE_W-1:0];
    assign word_done = byte_acc && (lane == LAST_LANE);

    always_comb begin
        for (int k = 0; k < WORD_BYTES; k++) begin
            full[k] = (k == WORD_BYTES - 1) ? in_data : held_q[k];
        end
    end

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        assign word_msbf[(WORD_BYTES-1-k)*8 +: 8] = full[k];
        assign word_lsbf[k*8 +: 8]                = full[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                held_q[k] <= '0;
            end
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            if (byte_acc && !word_done) begin
                held_q[lane] <= in_data;
            end
            out_valid <= word_done && keep;
            out_sop   <= word_done && keep && (byte_idx == FIRST_END);
            out_eop   <= word_done && keep && (byte_idx == PKT_END);
            if (word_done && keep) begin
                out_data <= lsb_first ? word_lsbf : word_msbf;
            end
        end
    end

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
    import tspf_pkg::*;
#(
    parameter int NSLOTS     = 8,
    parameter int PKT_BYTES  = 188,
    parameter int WORD_BYTES = 4,
    parameter int AW         = $clog2(NSLOTS),
    parameter int DW         = 8 * WORD_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic [7:0]    in_data,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop
);

    localparam int IDX_W = $clog2(PKT_BYTES);

    pid_t             pid;
    logic             keep_now;
    logic             lsb_now;
    logic             keep_q;
    logic             lsb_q;
    logic             byte_acc;
    logic [IDX_W-1:0] byte_idx;

    tspf_slot_bank #(.NSLOTS(NSLOTS), .AW(AW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pid       (pid),
        .keep      (keep_now),
        .lsb_first (lsb_now)
    );

    tspf_sync_track #(.PKT_BYTES(PKT_BYTES), .IDX_W(IDX_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_data  (in_data),
        .keep_in  (keep_now),
        .lsb_in   (lsb_now),
        .byte_acc (byte_acc),
        .byte_idx (byte_idx),
        .pid      (pid),
        .keep_q   (keep_q),
        .lsb_q    (lsb_q)
    );

    tspf_word_pack #(.PKT_BYTES(PKT_BYTES), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .byte_acc  (byte_acc),
        .byte_idx  (byte_idx),
        .in_data   (in_data),
        .keep      (keep_q),
        .lsb_first (lsb_q),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

endmodule

// File: rtl/tspf_checker.sv
module tspf_checker #(
    parameter int WORDS = 47
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic out_valid,
    input logic out_sop,
    input logic out_eop
);

    localparam int CW = $clog2(WORDS + 1);

    logic [CW-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
        end else if (out_valid) begin
            wcnt_q <= out_eop ? '0 : wcnt_q + CW'(1);
        end
    end

    // R1: reset clears the output on the next cycle
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !out_valid);

    a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_sop && !out_eop));

    a_r8_sop_first_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> (wcnt_q == '0));

    a_r8_eop_last_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eop) |-> (wcnt_q == CW'(WORDS - 1)));

    a_r10_word_after_byte: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

bind ts_pid_filter tspf_checker #(.WORDS(PKT_BYTES / WORD_BYTES)) u_tspf_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/tb_ts_pid_filter.sv
`timescale 1ns/1ps
module tb_ts_pid_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    int tests = 0;
    int fails = 0;

    int          nwords, nsop, neop, nframe_err;
    logic [31:0] first_word, last_word;

    always #2.5 clk = ~clk;

    ts_pid_filter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    // Output monitor
    always @(negedge clk) begin
        if (out_valid) begin
            if (nwords == 0) first_word = out_data;
            last_word = out_data;
            if (out_sop) begin
                nsop++;
                if (nwords != 0) nframe_err++;
            end
            if (out_eop) begin
                neop++;
                if (nwords != 46) nframe_err++;
            end
            nwords++;
        end
    end

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: %s actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic clear_mon();
        nwords = 0; nsop = 0; neop = 0; nframe_err = 0;
        first_word = '0; last_word = '0;
    endtask

    task automatic wr_slot(input int slot, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(slot); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] pkt_byte(input int i, input logic [12:0] pid,
                                            input logic [7:0] sync, input int sop_again);
        if (i == 0) return sync;
        if (i == 1) return {3'b010, pid[12:8]};
        if (i == 2) return pid[7:0];
        if (i == sop_again) return 8'h47;
        return 8'(i);
    endfunction

    task automatic send_pkt(input logic [12:0] pid, input logic [7:0] sync,
                            input int sop_again, input bit gaps);
        for (int i = 0; i < 188; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0) || (i == sop_again);
            in_data  = pkt_byte(i, pid, sync, sop_again);
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_first(input logic [12:0] pid, input bit lsbf);
        logic [31:0] w;
        w = {8'h47, 3'b010, pid[12:8], pid[7:0], 8'h03};
        return lsbf ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endfunction

    task automatic expect_fwd(input string tag, input logic [12:0] pid, input bit lsbf);
        check(tag, "word count", nwords, 47);
        check(tag, "sop count", nsop, 1);
        check(tag, "eop count", neop, 1);
        check(tag, "framing errors", nframe_err, 0);
        check(tag, "first word", first_word, exp_first(pid, lsbf));
        check(tag, "last word", last_word, lsbf ? 32'hBBBAB9B8 : 32'hB8B9BABB);
    endtask

    task automatic expect_drop(input string tag);
        check(tag, "word count (dropped)", nwords, 0);
    endtask

    // Scenarios
    task automatic t_reset();
        clear_mon();
        check("R1", "out_valid after reset", out_valid, 0);
        send_pkt(13'h1FFF, 8'h47, -1, 1'b0);
        expect_drop("R1");
    endtask

    task automatic t_match();
        wr_slot(3, 32'h0000_8123);
        clear_mon(); send_pkt(13'h0123, 8'h47, -1, 1'b0);
        expect_fwd("R3", 13'h0123, 1'b0);
        clear_mon(); send_pkt(13'h1123, 8'h47, -1, 1'b0);
        expect_drop("R3");
        clear_mon(); send_pkt(13'h0124, 8'h47, -1, 1'b0);
        expect_drop("R3");
    endtask

    task automatic t_disabled();
        wr_slot(3, 32'h0000_0123);
        clear_mon(); send_pkt(13'h0123, 8'h47, -1, 1'b0);
        expect_drop("R4");
    endtask

    task automatic t_pass_all();
        wr_slot(0, 32'h0001_0000);
        clear_mon(); send_pkt(13'h0555, 8'h47, -1, 1'b1);
        expect_fwd("R5", 13'h0555, 1'b0);
    endtask

    task automatic t_block_all();
        wr_slot(1, 32'h0000_8777);
        wr_slot(0, 32'h0001_2000);
        clear_mon(); send_pkt(13'h0777, 8'h47, -1, 1'b0);
        expect_drop("R6");
        wr_slot(1, 32'h0000_1FFF);
    endtask

    task automatic t_lsb_first();
        wr_slot(0, 32'h0001_4000);
        clear_mon(); send_pkt(13'h0A5C, 8'h47, -1, 1'b0);
        expect_fwd("R9", 13'h0A5C, 1'b1);
    endtask

    task automatic t_hold();
        wr_slot(0, 32'h0001_0000);
        clear_mon();
        fork
            send_pkt(13'h0333, 8'h47, -1, 1'b0);
            begin
                repeat (10) @(negedge clk);
                cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h0000_6000;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        expect_fwd("R7", 13'h0333, 1'b0);
        clear_mon(); send_pkt(13'h0333, 8'h47, -1, 1'b0);
        expect_drop("R7");
    endtask

    task automatic t_sync_hunt();
        wr_slot(0, 32'h0001_0000);
        clear_mon(); send_pkt(13'h0010, 8'h46, -1, 1'b0);
        expect_drop("R2");
        clear_mon(); send_pkt(13'h0010, 8'h47, -1, 1'b0);
        expect_fwd("R2", 13'h0010, 1'b0);
    endtask

    task automatic t_mid_sop();
        clear_mon(); send_pkt(13'h0042, 8'h47, 50, 1'b1);
        expect_fwd("R10", 13'h0042, 1'b0);
    endtask

    task automatic t_ctrl_bits_other_slot();
        wr_slot(0, 32'h0000_0000);
        wr_slot(5, 32'h0001_E050);
        clear_mon(); send_pkt(13'h0050, 8'h47, -1, 1'b0);
        expect_fwd("R11", 13'h0050, 1'b0);
        clear_mon(); send_pkt(13'h0051, 8'h47, -1, 1'b0);
        expect_drop("R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_match();
        t_disabled();
        t_pass_all();
        t_block_all();
        t_lsb_first();
        t_hold();
        t_sync_hunt();
        t_mid_sop();
        t_ctrl_bits_other_slot();
        summary();
    end

endmodule